// File: doc/BRIEF.md
# PCI Host Address Window Translator

This block sits behind a local bus slave port and turns accesses that land in a fixed 1 GiB local window into requests for a simplified PCI initiator. Each claimed access becomes one of two cycle types. A memory cycle forms its upper two address bits from a programmable field. A Type 0 configuration cycle passes through the low part of the window offset, where software has placed a one-hot IDSEL bit at position 13 plus the device number, the function number and the dword register index. A select bit in a small control register chooses between the two kinds of cycle. The block samples that bit when it accepts a transaction, so changing it never disturbs a cycle already in flight.

A second, register-only port holds three registers. One is a millisecond tick count, which stores a value and has no other effect here. One is a control register that selects the cycle kind, the upper memory address bits and the drive mode of the PCI reset pin. The last is a status register with a sticky, write-one-to-clear master-abort flag. An aborted read completes locally with all ones, so a missing device never hangs the local bus.

Top module: `pci_win_xlate`

## Requirements
- R1: A local access with `lb_addr[31:30] == 2'b10` (0x80000000 to 0xBFFFFFFF) is claimed. Any other address gets no `lb_ack` and raises no `pci_req`.
- R2: With control bit 1 clear, a claimed access issues a memory cycle. `pci_addr` is `{ctrl[3:2], lb_addr[29:0]}`, and `pci_cmd` is 4'b0110 for a read and 4'b0111 for a write.
- R3: With control bit 1 set, a claimed access issues a configuration cycle. `pci_addr` is the window offset bits 19:2 with bits 31:20 and 1:0 zero, so the IDSEL bit (13 + device), the function (bits 10:8) and the register index (bits 7:2) pass through. `pci_cmd` is 4'b1010 for a read and 4'b1011 for a write.
- R4: In configuration mode, an offset with any of bits 29:20 set produces no PCI cycle. The access is still acknowledged, a read returns 0xFFFFFFFF, and no abort is reported.
- R5: Control bits 5:4 set the reset pin. A value of 0 (or 3) releases it (`pci_rst_oe`=0). A value of 1 drives it low. A value of 2 drives it high.
- R6: A cycle that ends with `pci_abort` raises `abort_pulse` for exactly the acknowledge cycle and sets bit 26 of the status register at offset 0x500. Writing a 1 to that bit clears it, and writing a 0 leaves it set.
- R7: A successful read returns `pci_rdata` on `lb_rdata`, and an aborted read returns 0xFFFFFFFF. `lb_ack` is a single-cycle pulse.
- R8: Offset 0x08 holds an 18-bit tick count. Reads return it zero-extended, and higher write bits are dropped.
- R9: `pci_be` is active high. For size 0 (byte), it is `1 << lb_addr[1:0]`. For size 1 (half), it is `3 << (lb_addr[1]*2)`. For size 2 (word), it is 4'hF. Write data passes unchanged to `pci_wdata`.
- R10: The cycle kind, address and enables are fixed when an access is accepted. A control-register write made while `pci_req` is high changes none of them, and the new mode applies from the next access.
- R11: After reset, `pci_req` and `lb_ack` are low, the reset pin is released, and the control register, status register and tick count all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_req | input | 1 | Local access request, held until `lb_ack` |
| lb_we | input | 1 | Local access is a write |
| lb_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| lb_addr | input | 32 | Local byte address |
| lb_wdata | input | 32 | Local write data, lane aligned |
| lb_ack | output | 1 | One-cycle completion of a claimed access |
| lb_rdata | output | 32 | Read data, valid with `lb_ack` |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` |
| pci_req | output | 1 | PCI cycle request, held until `pci_done` |
| pci_cmd | output | 4 | PCI bus command |
| pci_addr | output | 32 | PCI address |
| pci_be | output | 4 | PCI byte enables, active high |
| pci_wdata | output | 32 | PCI write data |
| pci_done | input | 1 | Initiator reports the cycle finished |
| pci_abort | input | 1 | Cycle ended in master abort, valid with `pci_done` |
| pci_rdata | input | 32 | PCI read data, valid with `pci_done` |
| pci_rst_oe | output | 1 | Reset pin output enable |
| pci_rst_out | output | 1 | Reset pin level when enabled |
| abort_pulse | output | 1 | Master-abort event |

## Verification
The hardest case is a control-register write that lands while a PCI cycle is outstanding. From the ports, this requires a cycle that stays open long enough for the register write to complete. The bench holds back `pci_done` for several cycles after `pci_req` rises, flips the select bit through the register port in that gap, and confirms that the command and address do not change. It then checks that the next access uses the new mode. Rejected configuration offsets and out-of-window addresses are detected by watching `pci_req` for the whole access, since neither leaves any other trace.

// File: rtl/pwx_pkg.sv
// Package: shared types and register layout for the PCI window translator.
// Assumes 32-bit local and PCI data paths and 12-bit register offsets.
package pwx_pkg;
    localparam int OFF_W         = 12;
    localparam int DATA_W        = 32;
    localparam int LANES         = DATA_W / 8;
    localparam int CTRL_W        = 6;
    localparam int CTRL_CFG_BIT  = 1;
    localparam int CTRL_HI_LSB   = 2;
    localparam int CTRL_RST_LSB  = 4;
    localparam int STAT_ABT_BIT  = 26;

    localparam logic [OFF_W-1:0] OFF_TICK = 12'h008;
    localparam logic [OFF_W-1:0] OFF_CTRL = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_STAT = 12'h500;

    typedef enum logic [3:0] {
        CMD_MEM_RD = 4'b0110,
        CMD_MEM_WR = 4'b0111,
        CMD_CFG_RD = 4'b1010,
        CMD_CFG_WR = 4'b1011
    } pci_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_RESP
    } xfer_state_e;
endpackage

// File: rtl/pwx_regs.sv
// Module: control, tick-count and status registers of the translator.
// Also decodes the reset-pin drive mode. Assumes writes take one cycle
// and that an abort event and a clearing write in the same cycle resolve
// in favour of the event.
module pwx_regs
    import pwx_pkg::*;
#(
    parameter int TICK_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              abort_evt,
    output logic              cfg_sel,
    output logic [1:0]        addr_hi,
    output logic              pci_rst_oe,
    output logic              pci_rst_out
);
    logic [TICK_W-1:0] tick_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              stat_abt_q;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign cfg_sel      = ctrl_q[CTRL_CFG_BIT];
    assign addr_hi      = ctrl_q[CTRL_HI_LSB +: 2];

    // Register updates: plain stores, plus a sticky abort flag cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q     <= '0;
            ctrl_q     <= '0;
            stat_abt_q <= 1'b0;
        end else begin
            if (reg_wr && reg_off == OFF_TICK) tick_q <= reg_wdata[TICK_W-1:0];
            if (reg_wr && reg_off == OFF_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (abort_evt)
                stat_abt_q <= 1'b1;
            else if (reg_wr && reg_off == OFF_STAT && reg_wdata[STAT_ABT_BIT])
                stat_abt_q <= 1'b0;
        end
    end

    // Read mux: unmapped offsets read zero.
    always_comb begin
        unique case (reg_off)
            OFF_TICK: reg_rdata = {{(DATA_W-TICK_W){1'b0}}, tick_q};
            OFF_CTRL: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFF_STAT: reg_rdata = stat_abt_q ? (DATA_W'(1) << STAT_ABT_BIT) : '0;
            default:  reg_rdata = '0;
        endcase
    end

    // Reset pin decode: 1 drives low, 2 drives high, other codes release the pin.
    always_comb begin
        unique case (ctrl_q[CTRL_RST_LSB +: 2])
            2'd1:    begin pci_rst_oe = 1'b1; pci_rst_out = 1'b0; end
            2'd2:    begin pci_rst_oe = 1'b1; pci_rst_out = 1'b1; end
            default: begin pci_rst_oe = 1'b0; pci_rst_out = 1'b0; end
        endcase
    end

    a_r6_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> reg_off != OFF_STAT || reg_rdata[STAT_ABT_BIT] || reg_wr)
        else $error("R6: abort event did not set status");
endmodule

// File: rtl/pwx_addr_map.sv
// Module: combinational window decode and address translation.
// Works out whether an address is claimed, whether a configuration offset
// falls outside the configuration span, the PCI address and byte enables.
// Assumes the window is the quarter of the 32-bit space tagged WIN_TAG.
module pwx_addr_map
    import pwx_pkg::*;
#(
    parameter logic [1:0] WIN_TAG    = 2'b10,
    parameter int         CFG_SPAN_W = 20
) (
    input  logic [31:0]      lb_addr,
    input  logic [1:0]       lb_size,
    input  logic             cfg_sel,
    input  logic [1:0]       addr_hi,
    output logic             in_win,
    output logic             cfg_ovr,
    output logic [31:0]      xl_addr,
    output logic [LANES-1:0] xl_be
);
    localparam int OFF_BITS = 30;
    localparam int PAD_W    = 32 - CFG_SPAN_W;

    logic [OFF_BITS-1:0] win_off;

    assign win_off = lb_addr[OFF_BITS-1:0];
    assign in_win  = (lb_addr[31:30] == WIN_TAG);
    assign cfg_ovr = cfg_sel && (|win_off[OFF_BITS-1:CFG_SPAN_W]);
    assign xl_addr = cfg_sel ? {{PAD_W{1'b0}}, win_off[CFG_SPAN_W-1:2], 2'b00}
                             : {addr_hi, win_off};

    // One enable per byte lane, chosen by access size and low address bits.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE = 2'(i);
        assign xl_be[i] = (lb_size == 2'd0) ? (lb_addr[1:0] == LANE) :
                          (lb_size == 2'd1) ? (lb_addr[1] == LANE[1]) : 1'b1;
    end
endmodule

// File: rtl/pwx_fsm.sv
// Module: transaction sequencer. Accepts one claimed local access at a time,
// latches the cycle kind and address on acceptance, holds the PCI request
// until done, then gives a one-cycle local acknowledge. Assumes the local
// master holds lb_req until it sees lb_ack and drops it in that cycle.
module pwx_fsm
    import pwx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_req,
    input  logic              lb_we,
    input  logic [DATA_W-1:0] lb_wdata,
    input  logic              in_win,
    input  logic              cfg_ovr,
    input  logic              cfg_sel,
    input  logic [31:0]       xl_addr,
    input  logic [LANES-1:0]  xl_be,
    input  logic              pci_done,
    input  logic              pci_abort,
    input  logic [DATA_W-1:0] pci_rdata,
    output logic              lb_ack,
    output logic [DATA_W-1:0] lb_rdata,
    output logic              pci_req,
    output logic [3:0]        pci_cmd,
    output logic [31:0]       pci_addr,
    output logic [LANES-1:0]  pci_be,
    output logic [DATA_W-1:0] pci_wdata,
    output logic              abort_evt
);
    xfer_state_e       state_q;
    pci_cmd_e          cmd_q;
    logic [31:0]       addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              abort_q;

    assign pci_req   = (state_q == ST_BUSY);
    assign lb_ack    = (state_q == ST_RESP);
    assign pci_cmd   = cmd_q;
    assign pci_addr  = addr_q;
    assign pci_be    = be_q;
    assign pci_wdata = wdata_q;
    assign lb_rdata  = rdata_q;
    assign abort_evt = abort_q;

    // Sequencing: accept, forward or reject, collect completion, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_MEM_RD;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            abort_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    abort_q <= 1'b0;
                    if (lb_req && in_win) begin
                        if (cfg_ovr) begin
                            rdata_q <= '1;
                            state_q <= ST_RESP;
                        end else begin
                            cmd_q   <= cfg_sel ? (lb_we ? CMD_CFG_WR : CMD_CFG_RD)
                                               : (lb_we ? CMD_MEM_WR : CMD_MEM_RD);
                            addr_q  <= xl_addr;
                            be_q    <= xl_be;
                            wdata_q <= lb_wdata;
                            state_q <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (pci_done) begin
                        rdata_q <= pci_abort ? '1 : pci_rdata;
                        abort_q <= pci_abort;
                        state_q <= ST_RESP;
                    end
                end
                default: begin
                    abort_q <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    a_r10_frozen_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req && $past(pci_req) |->
            $stable(pci_cmd) && $stable(pci_addr) && $stable(pci_be))
        else $error("R10: request fields changed in flight");

    a_r6_abort_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |-> lb_ack)
        else $error("R6: abort pulse outside acknowledge");

    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ack |=> !lb_ack)
        else $error("R7: acknowledge longer than one cycle");

    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req |-> (pci_cmd == CMD_MEM_RD || pci_cmd == CMD_MEM_WR ||
                     pci_cmd == CMD_CFG_RD || pci_cmd == CMD_CFG_WR) && pci_be != '0)
        else $error("R2: illegal command or empty enables");
endmodule

// File: rtl/pci_win_xlate.sv
// Module: top of the PCI host address window translator.
// Wires the address map, the register block and the sequencer together.
// Assumes a single outstanding access and a synchronous active-low reset.
module pci_win_xlate
    import pwx_pkg::*;
#(
    parameter logic [1:0] WIN_TAG    = 2'b10,
    parameter int         CFG_SPAN_W = 20,
    parameter int         TICK_W     = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lb_req,
    input  logic        lb_we,
    input  logic [1:0]  lb_size,
    input  logic [31:0] lb_addr,
    input  logic [31:0] lb_wdata,
    output logic        lb_ack,
    output logic [31:0] lb_rdata,
    input  logic        reg_wr,
    input  logic [11:0] reg_off,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pci_req,
    output logic [3:0]  pci_cmd,
    output logic [31:0] pci_addr,
    output logic [3:0]  pci_be,
    output logic [31:0] pci_wdata,
    input  logic        pci_done,
    input  logic        pci_abort,
    input  logic [31:0] pci_rdata,
    output logic        pci_rst_oe,
    output logic        pci_rst_out,
    output logic        abort_pulse
);
    logic             cfg_sel;
    logic [1:0]       addr_hi;
    logic             in_win;
    logic             cfg_ovr;
    logic [31:0]      xl_addr;
    logic [LANES-1:0] xl_be;

    pwx_addr_map #(.WIN_TAG(WIN_TAG), .CFG_SPAN_W(CFG_SPAN_W)) u_map (
        .lb_addr (lb_addr),
        .lb_size (lb_size),
        .cfg_sel (cfg_sel),
        .addr_hi (addr_hi),
        .in_win  (in_win),
        .cfg_ovr (cfg_ovr),
        .xl_addr (xl_addr),
        .xl_be   (xl_be)
    );

    pwx_regs #(.TICK_W(TICK_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_off     (reg_off),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .abort_evt   (abort_pulse),
        .cfg_sel     (cfg_sel),
        .addr_hi     (addr_hi),
        .pci_rst_oe  (pci_rst_oe),
        .pci_rst_out (pci_rst_out)
    );

    pwx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lb_req    (lb_req),
        .lb_we     (lb_we),
        .lb_wdata  (lb_wdata),
        .in_win    (in_win),
        .cfg_ovr   (cfg_ovr),
        .cfg_sel   (cfg_sel),
        .xl_addr   (xl_addr),
        .xl_be     (xl_be),
        .pci_done  (pci_done),
        .pci_abort (pci_abort),
        .pci_rdata (pci_rdata),
        .lb_ack    (lb_ack),
        .lb_rdata  (lb_rdata),
        .pci_req   (pci_req),
        .pci_cmd   (pci_cmd),
        .pci_addr  (pci_addr),
        .pci_be    (pci_be),
        .pci_wdata (pci_wdata),
        .abort_evt (abort_pulse)
    );

    a_r1_no_req_outside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_req) |-> $past(lb_req) && $past(lb_addr[31:30]) == WIN_TAG)
        else $error("R1: request raised for an unclaimed address");
endmodule

// File: tb/test_pci_win_xlate.sv
// Bench: sweeps modes, sizes and address patterns; expected values are
// computed from the requirements.
module test_pci_win_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lb_req = 1'b0, lb_we = 1'b0;
    logic [1:0]  lb_size = 2'd2;
    logic [31:0] lb_addr = '0, lb_wdata = '0;
    logic        lb_ack;
    logic [31:0] lb_rdata;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pci_req;
    logic [3:0]  pci_cmd, pci_be;
    logic [31:0] pci_addr, pci_wdata;
    logic        pci_done = 1'b0, pci_abort = 1'b0;
    logic [31:0] pci_rdata = '0;
    logic        pci_rst_oe, pci_rst_out, abort_pulse;

    int n_chk = 0, n_fail = 0;
    bit got_ack, got_req, c_abt;
    logic [3:0]  c_cmd, c_be;
    logic [31:0] c_addr, c_wd, c_rd;

    always #5 clk = ~clk;

    pci_win_xlate i_pci_win_xlate (
        .clk(clk), .rst_n(rst_n), .lb_req(lb_req), .lb_we(lb_we),
        .lb_size(lb_size), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
        .lb_ack(lb_ack), .lb_rdata(lb_rdata), .reg_wr(reg_wr),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pci_req(pci_req), .pci_cmd(pci_cmd), .pci_addr(pci_addr),
        .pci_be(pci_be), .pci_wdata(pci_wdata), .pci_done(pci_done),
        .pci_abort(pci_abort), .pci_rdata(pci_rdata), .pci_rst_oe(pci_rst_oe),
        .pci_rst_out(pci_rst_out), .abort_pulse(abort_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic reg_write(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_off = off;
        #1 d = reg_rdata;
    endtask

    // Local access with a one-shot PCI target answering on the first request.
    task automatic access(input logic [31:0] a, input bit we, input logic [1:0] sz,
                          input logic [31:0] wd, input bit abt, input logic [31:0] prd);
        @(negedge clk);
        lb_addr = a; lb_we = we; lb_size = sz; lb_wdata = wd; lb_req = 1'b1;
        got_ack = 0; got_req = 0; c_abt = 0;
        for (int k = 0; k < 12 && !got_ack; k++) begin
            @(negedge clk);
            pci_done = 1'b0; pci_abort = 1'b0;
            if (lb_ack) begin
                got_ack = 1; c_rd = lb_rdata; c_abt = abort_pulse;
            end else if (pci_req && !got_req) begin
                got_req = 1; c_cmd = pci_cmd; c_addr = pci_addr;
                c_be = pci_be; c_wd = pci_wdata;
                pci_done = 1'b1; pci_abort = abt; pci_rdata = prd;
            end
        end
        lb_req = 1'b0;
        pci_done = 1'b0; pci_abort = 1'b0;
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] a);
        if (sz == 2'd0) return 4'(1 << a);
        if (sz == 2'd1) return 4'(3 << (a & 2'd2));
        return 4'hF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, a, e;
        logic [31:0] offs [4];
        offs[0] = 32'h0000_0000; offs[1] = 32'h3FFF_FFFC;
        offs[2] = 32'h1234_5678; offs[3] = 32'h2000_0104;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        @(negedge clk);
        check(!pci_req && !lb_ack, "R11 idle outputs", {30'd0, pci_req, lb_ack}, 0);
        check(!pci_rst_oe, "R11 reset pin released", {31'd0, pci_rst_oe}, 0);
        reg_read(12'h00C, d); check(d == 0, "R11 control", d, 0);
        reg_read(12'h500, d); check(d == 0, "R11 status", d, 0);
        reg_read(12'h008, d); check(d == 0, "R11 tick", d, 0);

        // R8: tick register width
        reg_write(12'h008, 32'hFFFF_FFFF);
        reg_read(12'h008, d); check(d == 32'h3FFFF, "R8 tick truncation", d, 32'h3FFFF);
        reg_write(12'h008, 32'h0001_2345);
        reg_read(12'h008, d); check(d == 32'h12345, "R8 tick value", d, 32'h12345);

        // R5: reset pin modes
        for (int m = 0; m < 4; m++) begin
            reg_write(12'h00C, 32'(m << 4));
            @(negedge clk);
            check(pci_rst_oe == (m == 1 || m == 2), "R5 pin enable", {31'd0, pci_rst_oe},
                  32'(m == 1 || m == 2));
            if (m == 1 || m == 2)
                check(pci_rst_out == (m == 2), "R5 pin level", {31'd0, pci_rst_out}, 32'(m == 2));
        end

        // R2/R7: memory cycles for every upper-bit setting
        for (int g = 0; g < 4; g++) begin
            reg_write(12'h00C, 32'(g << 2));
            for (int j = 0; j < 4; j++) begin
                a = 32'h8000_0000 | offs[j];
                e = {2'(g), a[29:0]};
                access(a, 1'b0, 2'd2, 0, 1'b0, 32'hA5A5_0000 + 32'(g * 4 + j));
                check(got_req && c_cmd == 4'b0110, "R2 mem read cmd", {28'd0, c_cmd}, 32'h6);
                check(c_addr == e, "R2 mem address", c_addr, e);
                check(got_ack && c_rd == 32'hA5A5_0000 + 32'(g * 4 + j), "R7 read data",
                      c_rd, 32'hA5A5_0000 + 32'(g * 4 + j));
            end
            access(32'hBFFF_FFF0, 1'b1, 2'd2, 32'hCAFE_0000 + 32'(g), 1'b0, 0);
            check(got_req && c_cmd == 4'b0111, "R2 mem write cmd", {28'd0, c_cmd}, 32'h7);
            check(got_ack, "R1 upper edge claimed", {31'd0, got_ack}, 1);
        end

        // R9: byte enables for every size and alignment
        reg_write(12'h00C, 0);
        for (int s = 0; s < 3; s++)
            for (int lo = 0; lo < 4; lo++) begin
                access(32'h8000_0040 | 32'(lo), 1'b1, 2'(s), 32'h1122_3344 ^ 32'(lo), 1'b0, 0);
                check(c_be == exp_be(2'(s), 2'(lo)), "R9 byte enables", {28'd0, c_be},
                      {28'd0, exp_be(2'(s), 2'(lo))});
                check(c_wd == (32'h1122_3344 ^ 32'(lo)), "R9 write data", c_wd,
                      32'h1122_3344 ^ 32'(lo));
            end

        // R3: configuration cycles across devices, functions and registers
        reg_write(12'h00C, 32'h2);
        for (int dv = 0; dv < 7; dv++)
            for (int fn = 0; fn < 8; fn++) begin
                e = (32'd1 << (13 + dv)) | 32'(fn << 8) | 32'(((dv * 9 + fn) & 63) << 2);
                access(32'h8000_0000 | e, 1'b0, 2'd2, 0, 1'b0, 32'h5A00_0000 + e);
                check(got_req && c_cmd == 4'b1010, "R3 cfg read cmd", {28'd0, c_cmd}, 32'hA);
                check(c_addr == e, "R3 cfg address", c_addr, e);
            end
        access(32'h8000_2010, 1'b1, 2'd0, 32'h0000_7700, 1'b0, 0);
        check(c_cmd == 4'b1011 && c_addr == 32'h2010, "R3 cfg write", c_addr, 32'h2010);

        // R4: configuration offsets beyond the span
        for (int j = 0; j < 3; j++) begin
            a = (j == 0) ? 32'h8010_0000 : (j == 1) ? 32'h8200_2000 : 32'hBFFF_FFFC;
            access(a, 1'b0, 2'd2, 0, 1'b0, 32'h1);
            check(got_ack && !got_req, "R4 no cycle", {30'd0, got_ack, got_req}, 32'h2);
            check(c_rd == 32'hFFFF_FFFF, "R4 all ones", c_rd, 32'hFFFF_FFFF);
            check(!c_abt, "R4 no abort", {31'd0, c_abt}, 0);
        end
        reg_read(12'h500, d); check(d == 0, "R4 status untouched", d, 0);

        // R1: addresses outside the window
        for (int j = 0; j < 4; j++) begin
            a = (j == 0) ? 32'h0 : (j == 1) ? 32'h7FFF_FFFC : (j == 2) ? 32'hC000_0000 : 32'hFFFF_FFFC;
            access(a, 1'b0, 2'd2, 0, 1'b0, 0);
            check(!got_ack && !got_req, "R1 not claimed", {30'd0, got_ack, got_req}, 0);
        end

        // R6/R7: master abort in both modes
        for (int md = 0; md < 2; md++) begin
            reg_write(12'h00C, 32'(md << 1));
            access(32'h8000_4000, 1'b0, 2'd2, 0, 1'b1, 32'h1234_5678);
            check(c_rd == 32'hFFFF_FFFF, "R7 aborted read", c_rd, 32'hFFFF_FFFF);
            check(c_abt, "R6 abort pulse", {31'd0, c_abt}, 1);
            @(negedge clk);
            check(!abort_pulse, "R6 pulse one cycle", {31'd0, abort_pulse}, 0);
            reg_read(12'h500, d); check(d == 32'h0400_0000, "R6 status set", d, 32'h0400_0000);
            reg_write(12'h500, 32'h0000_0001);
            reg_read(12'h500, d); check(d == 32'h0400_0000, "R6 zero write keeps", d, 32'h0400_0000);
            reg_write(12'h500, 32'h0400_0000);
            reg_read(12'h500, d); check(d == 0, "R6 clear", d, 0);
        end

        // R10: select bit changed while a memory cycle is outstanding
        reg_write(12'h00C, 0);
        @(negedge clk);
        lb_addr = 32'h8000_1000; lb_we = 1'b0; lb_size = 2'd2; lb_req = 1'b1;
        for (int k = 0; k < 10 && !pci_req; k++) @(negedge clk);
        check(pci_req && pci_cmd == 4'b0110, "R10 started as memory", {28'd0, pci_cmd}, 32'h6);
        reg_write(12'h00C, 32'h2);
        repeat (2) @(negedge clk);
        check(pci_req && pci_cmd == 4'b0110, "R10 command held", {28'd0, pci_cmd}, 32'h6);
        check(pci_addr == 32'h0000_1000, "R10 address held", pci_addr, 32'h1000);
        pci_done = 1'b1; pci_rdata = 32'h0BAD_F00D;
        @(negedge clk);
        pci_done = 1'b0;
        check(lb_ack && lb_rdata == 32'h0BAD_F00D, "R10 completes", lb_rdata, 32'h0BAD_F00D);
        lb_req = 1'b0;
        access(32'h8000_4004, 1'b0, 2'd2, 0, 1'b0, 0);
        check(c_cmd == 4'b1010 && c_addr == 32'h4004, "R10 next uses new mode", c_addr, 32'h4004);

        summary();
        $finish;
    end
endmodule